// File: doc/BRIEF.md
# 4-bit Accumulator Execution Unit

This block is the data path of a small 4-bit accumulator machine. It holds the accumulator and the carry flag. Each cycle it combines a 4-bit operand with a second term, which is either the accumulator or a 4-bit immediate. The operand is a memory word or a working register. The unit produces the next accumulator value and the next carry. It also gives a write-back value and an enable, which tell the surrounding memory whether to update the operand location. Subtraction is done by adding the operand to the complement of the second term, so the accumulator acts as the subtrahend.

The decoder presents an operation code, a write-back select, an immediate select and a shift fill bit. All results are combinational. The accumulator and carry registers load on the rising clock edge only while `valid` is high. Branch-condition outputs come from the registered state: zero, non-zero, carry, and one selectable accumulator bit.

Top module: `acc_alu4`

## Requirements
- R1: After an active-low reset `acc` and `cf` are both 0.
- R2: Op 0 (add with carry) gives `res` = low 4 bits of operand + term + `cf`; op 2 (add) gives operand + term. Both set `cf_next` to the carry out of bit 3.
- R3: Op 1 (subtract with borrow) gives operand + NOT(term) + `cf`; op 3 (subtract) gives operand + NOT(term) + 1. Both set `cf_next` to the carry out of bit 3.
- R4: Op 4 (add, carry kept) gives operand + term and leaves the carry unchanged.
- R5: Ops 5, 6 and 7 give the bitwise AND, XOR and OR of operand and term, and leave the carry unchanged.
- R6: With `imm_sel` = 1 the term is `imm`; with `imm_sel` = 0 the term is `acc`.
- R7: For ops 0 to 7 and op 9, `wr_en` follows `wb`. When `wr_en` is 1, `wr_data` equals `res`.
- R8: Op 8 loads `imm` into `res` with `wr_en` = 1. Op 9 loads the operand into `res`. Op 10 keeps `res` = `acc` and writes `acc` back with `wr_en` = 1. None of these change the carry.
- R9: Op 11 gives {fill, operand[3:1]} and op 12 gives {operand[2:0], fill}. Both write back (`wr_en` = 1), discard the bit shifted out, and keep the carry.
- R10: `br_zero` is (acc == 0), `br_nonzero` is its complement, `br_carry` is `cf`, and `br_bit` is `acc[bit_sel]`.
- R11: `acc` and `cf` take `res` and `cf_next` on a clock edge only when `valid` is 1. When `valid` is 0, `wr_en` is 0. Opcodes 13 to 15 change nothing and do not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Execute strobe for this cycle |
| op | input | 4 | Operation code |
| wb | input | 1 | Also write result to operand location |
| imm_sel | input | 1 | Use immediate as second term |
| fill | input | 1 | Bit shifted in by shift operations |
| opnd | input | 4 | Memory or working-register operand |
| imm | input | 4 | Immediate constant |
| bit_sel | input | 2 | Accumulator bit chosen for bit test |
| res | output | 4 | Next accumulator value |
| cf_next | output | 1 | Next carry flag |
| wr_en | output | 1 | Write-back enable for operand location |
| wr_data | output | 4 | Write-back value |
| acc | output | 4 | Accumulator register |
| cf | output | 1 | Carry flag register |
| br_zero | output | 1 | Accumulator is zero |
| br_nonzero | output | 1 | Accumulator is non-zero |
| br_carry | output | 1 | Carry flag set |
| br_bit | output | 1 | Selected accumulator bit |

## Verification
`res`, `cf_next`, `wr_en` and `wr_data` are combinational, so they are due in the same cycle the inputs are applied. The bench drives inputs on the falling edge and samples these outputs one time unit later. `acc`, `cf` and the branch outputs change one rising edge later, so they are sampled one time unit after that edge. Each scenario chains operations whose expected carry and accumulator were worked out by hand from the previous step.

// File: rtl/acc_alu4.sv
module acc_alu4 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic [3:0]   op,
  input  logic         wb,
  input  logic         imm_sel,
  input  logic         fill,
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] imm,
  input  logic [$clog2(W)-1:0] bit_sel,
  output logic [W-1:0] res,
  output logic         cf_next,
  output logic         wr_en,
  output logic [W-1:0] wr_data,
  output logic [W-1:0] acc,
  output logic         cf,
  output logic         br_zero,
  output logic         br_nonzero,
  output logic         br_carry,
  output logic         br_bit
);
  localparam logic [3:0] OP_ADC = 4'd0, OP_SBC = 4'd1, OP_ADD = 4'd2, OP_SUB = 4'd3,
                         OP_ADN = 4'd4, OP_AND = 4'd5, OP_XOR = 4'd6, OP_OR  = 4'd7,
                         OP_LDI = 4'd8, OP_LDA = 4'd9, OP_STA = 4'd10,
                         OP_SHR = 4'd11, OP_SHL = 4'd12;

  logic [W-1:0] term, addend;
  logic         cin, is_sub;
  logic [W:0]   sum;
  logic         we_raw;

  assign term   = imm_sel ? imm : acc;
  assign is_sub = (op == OP_SBC) || (op == OP_SUB);
  assign addend = is_sub ? ~term : term;

  always_comb begin
    case (op)
      OP_ADC, OP_SBC: cin = cf;
      OP_SUB:         cin = 1'b1;
      default:        cin = 1'b0;
    endcase
  end

  assign sum = {1'b0, opnd} + {1'b0, addend} + {{W{1'b0}}, cin};

  always_comb begin
    res     = acc;
    cf_next = cf;
    we_raw  = 1'b0;
    case (op)
      OP_ADC, OP_SBC, OP_ADD, OP_SUB: begin
        res = sum[W-1:0]; cf_next = sum[W]; we_raw = wb;
      end
      OP_ADN: begin res = sum[W-1:0]; we_raw = wb; end
      OP_AND: begin res = opnd & term; we_raw = wb; end
      OP_XOR: begin res = opnd ^ term; we_raw = wb; end
      OP_OR:  begin res = opnd | term; we_raw = wb; end
      OP_LDI: begin res = imm;  we_raw = 1'b1; end
      OP_LDA: begin res = opnd; we_raw = wb; end
      OP_STA: begin res = acc;  we_raw = 1'b1; end
      OP_SHR: begin res = {fill, opnd[W-1:1]}; we_raw = 1'b1; end
      OP_SHL: begin res = {opnd[W-2:0], fill}; we_raw = 1'b1; end
      default: ;
    endcase
  end

  assign wr_en   = valid & we_raw;
  assign wr_data = res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cf  <= 1'b0;
    end else if (valid) begin
      acc <= res;
      cf  <= cf_next;
    end
  end

  assign br_zero    = (acc == '0);
  assign br_nonzero = ~br_zero;
  assign br_carry   = cf;
  assign br_bit     = acc[bit_sel];

  AST_LOAD_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> (acc == $past(res)) && (cf == $past(cf_next))); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(acc) && $stable(cf)); // R11
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !wr_en); // R11
  AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (op >= OP_ADN) |=> $stable(cf)); // R4
  AST_STORE_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op == OP_STA |-> wr_en && wr_data == acc); // R8
  AST_SHIFT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op == OP_SHR |-> wr_en && wr_data[W-1] == fill && wr_data[W-2:0] == opnd[W-1:1]); // R9
endmodule

// File: tb/acc_alu4_tb.sv
module acc_alu4_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, wb = 1'b0, imm_sel = 1'b0, fill = 1'b0;
  logic [3:0] op = 4'd0, opnd = 4'd0, imm = 4'd0;
  logic [1:0] bit_sel = 2'd0;
  logic [3:0] res, wr_data, acc;
  logic cf_next, wr_en, cf, br_zero, br_nonzero, br_carry, br_bit;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  acc_alu4 u_dut (.clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .wb(wb),
    .imm_sel(imm_sel), .fill(fill), .opnd(opnd), .imm(imm), .bit_sel(bit_sel),
    .res(res), .cf_next(cf_next), .wr_en(wr_en), .wr_data(wr_data), .acc(acc),
    .cf(cf), .br_zero(br_zero), .br_nonzero(br_nonzero), .br_carry(br_carry),
    .br_bit(br_bit));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, logic [3:0] o, bit w, bit is, bit f,
                      logic [3:0] a, logic [3:0] im, logic [3:0] er, bit ec, bit ewe);
    @(negedge clk);
    valid = v; op = o; wb = w; imm_sel = is; fill = f; opnd = a; imm = im;
    #1;
    check({tag, " res"}, res, er);
    check({tag, " cf_next"}, cf_next, ec);
    check({tag, " wr_en"}, wr_en, ewe);
    if (ewe) check({tag, " wr_data"}, wr_data, er);
    @(posedge clk); #1;
    check({tag, " acc"}, acc, er);
    check({tag, " cf"}, cf, ec);
    valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 acc", acc, 0);
    check("R1 cf", cf, 0);
    check("R10 zero at reset", br_zero, 1);
    check("R10 nonzero at reset", br_nonzero, 0);
  endtask

  task automatic t_add();
    step("R8 ldi5", 1, 8, 0, 0, 0, 4'h3, 4'h5, 4'h5, 0, 1);
    step("R2 adc", 1, 0, 0, 0, 0, 4'h3, 4'h0, 4'h8, 0, 0);
    step("R2 add carry", 1, 2, 0, 0, 0, 4'h9, 4'h0, 4'h1, 1, 0);
    step("R2 adc cin", 1, 0, 1, 0, 0, 4'hF, 4'h0, 4'h1, 1, 1);
    step("R2 adc clr", 1, 0, 0, 0, 0, 4'h2, 4'h0, 4'h4, 0, 0);
  endtask

  task automatic t_sub();
    step("R3 sub", 1, 3, 0, 0, 0, 4'h7, 4'h0, 4'h3, 1, 0);
    step("R3 sbc cin1", 1, 1, 1, 0, 0, 4'h2, 4'h0, 4'hF, 0, 1);
    step("R3 sbc cin0", 1, 1, 0, 0, 0, 4'h5, 4'h0, 4'h5, 0, 0);
    step("R3 sub equal", 1, 3, 0, 0, 0, 4'h5, 4'h0, 4'h0, 1, 0);
  endtask

  task automatic t_adn();
    step("R4 adn keep1", 1, 4, 1, 0, 0, 4'h9, 4'h0, 4'h9, 1, 1);
    step("R4 adn wrap", 1, 4, 0, 0, 0, 4'h8, 4'h0, 4'h1, 1, 0);
    step("R2 add clear", 1, 2, 0, 0, 0, 4'h0, 4'h0, 4'h1, 0, 0);
    step("R4 adn keep0", 1, 4, 0, 0, 0, 4'hF, 4'h0, 4'h0, 0, 0);
  endtask

  task automatic t_logic();
    step("R8 ldiC", 1, 8, 0, 0, 0, 4'h0, 4'hC, 4'hC, 0, 1);
    step("R5 and", 1, 5, 0, 0, 0, 4'hA, 4'h0, 4'h8, 0, 0);
    step("R5 xor", 1, 6, 0, 0, 0, 4'h3, 4'h0, 4'hB, 0, 0);
    step("R5 or wb", 1, 7, 1, 0, 0, 4'h4, 4'h0, 4'hF, 0, 1);
    step("R2 add set", 1, 2, 0, 0, 0, 4'h1, 4'h0, 4'h0, 1, 0);
    step("R5 or keep", 1, 7, 0, 0, 0, 4'h6, 4'h0, 4'h6, 1, 0);
  endtask

  task automatic t_imm();
    step("R6 add imm", 1, 2, 0, 1, 0, 4'h3, 4'h4, 4'h7, 0, 0);
    step("R6 sub imm", 1, 3, 1, 1, 0, 4'h2, 4'h3, 4'hF, 0, 1);
    step("R6 xor imm", 1, 6, 1, 1, 0, 4'h5, 4'h5, 4'h0, 0, 1);
  endtask

  task automatic t_move();
    step("R8 ldiA", 1, 8, 0, 0, 0, 4'h3, 4'hA, 4'hA, 0, 1);
    step("R8 sta", 1, 10, 0, 0, 0, 4'h5, 4'h0, 4'hA, 0, 1);
    step("R7 lda nowb", 1, 9, 0, 0, 0, 4'h9, 4'h0, 4'h9, 0, 0);
    step("R7 lda wb", 1, 9, 1, 0, 0, 4'h6, 4'h0, 4'h6, 0, 1);
  endtask

  task automatic t_shift();
    step("R9 shr fill1", 1, 11, 0, 0, 1, 4'hA, 4'h0, 4'hD, 0, 1);
    step("R9 shr fill0", 1, 11, 0, 0, 0, 4'h1, 4'h0, 4'h0, 0, 1);
    step("R9 shl fill0", 1, 12, 0, 0, 0, 4'h9, 4'h0, 4'h2, 0, 1);
    step("R9 shl fill1", 1, 12, 0, 0, 1, 4'h7, 4'h0, 4'hF, 0, 1);
  endtask

  task automatic t_branch();
    for (int i = 0; i < 4; i++) begin
      bit_sel = i[1:0]; #1;
      check("R10 bit of F", br_bit, 1);
    end
    check("R10 nonzero", br_nonzero, 1);
    step("R10 ldi4", 1, 8, 0, 0, 0, 4'h0, 4'h4, 4'h4, 0, 1);
    bit_sel = 2'd2; #1; check("R10 bit2", br_bit, 1);
    bit_sel = 2'd0; #1; check("R10 bit0", br_bit, 0);
    bit_sel = 2'd3; #1; check("R10 bit3", br_bit, 0);
    check("R10 carry0", br_carry, 0);
    step("R10 add to zero", 1, 2, 0, 0, 0, 4'hC, 4'h0, 4'h0, 1, 0);
    check("R10 zero", br_zero, 1);
    check("R10 carry1", br_carry, 1);
  endtask

  task automatic t_idle();
    @(negedge clk);
    valid = 0; op = 4'd2; wb = 1; opnd = 4'hF; #1;
    check("R11 idle wr_en", wr_en, 0);
    @(posedge clk); #1;
    check("R11 idle acc", acc, 0);
    check("R11 idle cf", cf, 1);
    step("R11 nop", 1, 13, 1, 0, 0, 4'h7, 4'h3, 4'h0, 1, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3; t_reset();
    #10 rst_n = 1'b1;
    t_add(); t_sub(); t_adn(); t_logic(); t_imm();
    t_move(); t_shift(); t_branch(); t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule